// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block sits on the CPU side of an 8-input interrupt controller. It watches a two-address register port (one address bit, an 8-bit data bus, an active-low write strobe and an active-low chip select). It walks through the 2 to 4 initialization command words and stores what each one configures. When the sequence is complete, it raises a ready flag. From then on it routes every write as an operation command word: to the mask register, or as a one-cycle pulse with the data for the command decoders that sit outside this block.

The bus inputs are asynchronous to the system clock. They pass through a synchronizer. A write takes effect on the rising edge of the strobe, using the address, data and chip select held while the strobe was low. The first initialization word fixes how many words follow: the cascade-mode flag adds a cascade word, and the extended-word flag adds a final word. The first word also restarts everything and clears a defined set of state. The priority resolver, edge detectors and command-word decoders take this as a one-cycle clear pulse.

Top module: `pic_init_seq`

## Requirements
- R1: A completed write with a0 = 0 and din[4] = 1 is the first initialization word in any state; in the cycle after it is accepted, ready is 0.
- R2: In the cycle after the first word is accepted, mask, casc_cfg and icw4_cfg read 0 and init_clear is 1 for exactly one cycle (edge-sense reset, input 7 lowest priority, special mask off, status read of the request register); icw1_flags takes din[3:0] (bit 0 extended-word needed, bit 1 single mode, bit 2 interval, bit 3 level-trigger).
- R3: The next a0 = 1 write after the first word loads vec_base with din[7:3].
- R4: When icw1_flags[1] = 0, the following a0 = 1 write loads casc_cfg with din.
- R5: When icw1_flags[1] = 1, no cascade word is taken and casc_cfg stays 0.
- R6: When icw1_flags[0] = 1, the last a0 = 1 write of the sequence loads icw4_cfg with din[4:0]; when it is 0, icw4_cfg stays 0.
- R7: ready rises three clock edges after the rising edge of wr_n that completes the last required word (2 to 4 words in all), and stays low until then.
- R8: With ready = 1, an a0 = 1 write loads mask with din.
- R9: With ready = 1, an a0 = 0 write with din[4] = 0 gives a one-cycle pulse on ocw2_wr if din[3] = 0 or on ocw3_wr if din[3] = 1, with ocw_data = din.
- R10: A strobe given while cs_n is high changes no output.
- R11: Before ready, an a0 = 0 write with din[4] = 0 is ignored: no ocw pulse, and the word position in the sequence does not change.
- R12: After reset, ready, mask, vec_base, casc_cfg, icw1_flags, icw4_cfg, init_clear, ocw2_wr and ocw3_wr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| a0 | input | 1 | Register address bit |
| din | input | 8 | Write data |
| ready | output | 1 | Initialization complete |
| init_clear | output | 1 | One-cycle clear pulse to the priority, edge and read-select logic |
| mask | output | 8 | Interrupt mask register |
| vec_base | output | 5 | Vector base bits from the second word |
| casc_cfg | output | 8 | Cascade configuration word |
| icw1_flags | output | 4 | Low flags of the first word |
| icw4_cfg | output | 5 | Extended configuration fields |
| ocw2_wr | output | 1 | Pulse: second operation command word |
| ocw3_wr | output | 1 | Pulse: third operation command word |
| ocw_data | output | 8 | Data that goes with the command pulses |

## Verification
The sequencer is tried with the four flag combinations of the first word. Each gives a different sequence length and word order: a 4-word cascade sequence with an extended word, a 3-word single sequence whose last byte would land in casc_cfg if the cascade word were wrongly taken, a 2-word sequence, and a 3-word cascade sequence with no extended word. Further patterns are a restart in the middle of a sequence, a stray command-style write before ready, a write with chip select high, and the mask and command routing after ready. Together they show whether the word steering, the clearing side effects and the command routing each act alone. The ready edge is timed cycle by cycle after a strobe to confirm the synchronizer latency.

// File: rtl/pic_init_pkg.sv
// Package: shared state type and bit positions of the command words.
// Assumes an 8-bit data bus; the bit positions are fixed by the word formats.
package pic_init_pkg;
    typedef enum logic [2:0] {
        SQ_OFF  = 3'd0,
        SQ_ICW2 = 3'd1,
        SQ_ICW3 = 3'd2,
        SQ_ICW4 = 3'd3,
        SQ_RUN  = 3'd4
    } seq_state_t;

    localparam int BIT_IC4    = 0;
    localparam int BIT_SNGL   = 1;
    localparam int BIT_CMDSEL = 4;
    localparam int BIT_OCWSEL = 3;
endpackage

// File: rtl/pic_wr_sync.sv
// Write capture: brings the asynchronous bus into the clock domain through
// STAGES flops, then one more to find the rising edge of wr_n. Assumes a0,
// din and cs_n are stable while wr_n is low; these values come out with evt.
module pic_wr_sync #(
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic          cs_n,
    input  logic          a0,
    input  logic [DW-1:0] din,
    output logic          evt,
    output logic          ev_a0,
    output logic [DW-1:0] ev_dat
);
    localparam int W     = DW + 3;
    localparam int B_WR  = DW + 2;
    localparam int B_CS  = DW + 1;
    localparam int B_A0  = DW;
    localparam logic [W-1:0] IDLE = {1'b1, 1'b1, 1'b0, {DW{1'b0}}};

    logic [W-1:0] stg [STAGES+1];

    genvar i;
    generate
        for (i = 0; i <= STAGES; i++) begin : g_stage
            // Stage i of the capture chain; stage 0 takes the pins.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg[i] <= IDLE;
                else if (i == 0)
                    stg[i] <= {wr_n, cs_n, a0, din};
                else
                    stg[i] <= stg[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    // Strobe rising edge, qualified by chip select held during the low phase.
    always_comb begin
        evt    = stg[STAGES-1][B_WR] && !stg[STAGES][B_WR] && !stg[STAGES][B_CS];
        ev_a0  = stg[STAGES][B_A0];
        ev_dat = stg[STAGES][DW-1:0];
    end
endmodule

// File: rtl/pic_seq_fsm.sv
// Sequencer: steers each captured write to a word slot from the current
// state and the flags of the first word, and keeps the registered ready flag.
// Assumes flags are already stored when the second word arrives.
module pic_seq_fsm
    import pic_init_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic          ev_a0,
    input  logic [DW-1:0] ev_dat,
    input  logic          flg_sngl,
    input  logic          flg_ic4,
    output logic          ready,
    output logic          ld_icw1,
    output logic          ld_icw2,
    output logic          ld_icw3,
    output logic          ld_icw4,
    output logic          ld_mask,
    output logic          ld_ocw2,
    output logic          ld_ocw3
);
    seq_state_t st, nxt;
    logic       is_icw1;

    // Next state and load enables for the current write.
    always_comb begin
        is_icw1 = evt && !ev_a0 && ev_dat[BIT_CMDSEL];
        nxt     = st;
        ld_icw1 = 1'b0;
        ld_icw2 = 1'b0;
        ld_icw3 = 1'b0;
        ld_icw4 = 1'b0;
        ld_mask = 1'b0;
        ld_ocw2 = 1'b0;
        ld_ocw3 = 1'b0;
        if (is_icw1) begin
            ld_icw1 = 1'b1;
            nxt     = SQ_ICW2;
        end else if (evt) begin
            case (st)
                SQ_ICW2: if (ev_a0) begin
                    ld_icw2 = 1'b1;
                    nxt = !flg_sngl ? SQ_ICW3 : (flg_ic4 ? SQ_ICW4 : SQ_RUN);
                end
                SQ_ICW3: if (ev_a0) begin
                    ld_icw3 = 1'b1;
                    nxt = flg_ic4 ? SQ_ICW4 : SQ_RUN;
                end
                SQ_ICW4: if (ev_a0) begin
                    ld_icw4 = 1'b1;
                    nxt = SQ_RUN;
                end
                SQ_RUN: begin
                    if (ev_a0)                   ld_mask = 1'b1;
                    else if (ev_dat[BIT_OCWSEL]) ld_ocw3 = 1'b1;
                    else                         ld_ocw2 = 1'b1;
                end
                default: nxt = st;
            endcase
        end
    end

    // State register and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= SQ_OFF;
            ready <= 1'b0;
        end else begin
            st    <= nxt;
            ready <= (nxt == SQ_RUN);
        end
    end
endmodule

// File: rtl/pic_cfg_store.sv
// Configuration store: holds the words written during initialization and the
// mask, applies the clearing side effects of the first word, and registers
// the command pulses. Assumes at most one load enable is active per cycle.
module pic_cfg_store #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ev_dat,
    input  logic          ld_icw1,
    input  logic          ld_icw2,
    input  logic          ld_icw3,
    input  logic          ld_icw4,
    input  logic          ld_mask,
    input  logic          ld_ocw2,
    input  logic          ld_ocw3,
    output logic [3:0]    icw1_flags,
    output logic [4:0]    vec_base,
    output logic [DW-1:0] casc_cfg,
    output logic [4:0]    icw4_cfg,
    output logic [DW-1:0] mask,
    output logic          init_clear,
    output logic          ocw2_wr,
    output logic          ocw3_wr,
    output logic [DW-1:0] ocw_data
);
    localparam int VEC_LO = DW - 5;

    // Initialization words; the first word clears the later ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icw1_flags <= '0;
            vec_base   <= '0;
            casc_cfg   <= '0;
            icw4_cfg   <= '0;
        end else if (ld_icw1) begin
            icw1_flags <= ev_dat[3:0];
            casc_cfg   <= '0;
            icw4_cfg   <= '0;
        end else begin
            if (ld_icw2) vec_base <= ev_dat[DW-1:VEC_LO];
            if (ld_icw3) casc_cfg <= ev_dat;
            if (ld_icw4) icw4_cfg <= ev_dat[4:0];
        end
    end

    // Mask register: cleared by the first word, loaded by the mask command.
    always_ff @(posedge clk) begin
        if (!rst_n || ld_icw1) mask <= '0;
        else if (ld_mask)      mask <= ev_dat;
    end

    // One-cycle pulses for the clear and the command words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_clear <= 1'b0;
            ocw2_wr    <= 1'b0;
            ocw3_wr    <= 1'b0;
            ocw_data   <= '0;
        end else begin
            init_clear <= ld_icw1;
            ocw2_wr    <= ld_ocw2;
            ocw3_wr    <= ld_ocw3;
            if (ld_ocw2 || ld_ocw3) ocw_data <= ev_dat;
        end
    end
endmodule

// File: rtl/pic_init_seq.sv
// Top: initialization sequencer of an 8-input interrupt controller port.
// Assumes asynchronous bus inputs; all state sits in the clk domain.
module pic_init_seq #(
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic          a0,
    input  logic [DW-1:0] din,
    output logic          ready,
    output logic          init_clear,
    output logic [DW-1:0] mask,
    output logic [4:0]    vec_base,
    output logic [DW-1:0] casc_cfg,
    output logic [3:0]    icw1_flags,
    output logic [4:0]    icw4_cfg,
    output logic          ocw2_wr,
    output logic          ocw3_wr,
    output logic [DW-1:0] ocw_data
);
    logic          evt, ev_a0;
    logic [DW-1:0] ev_dat;
    logic ld_icw1, ld_icw2, ld_icw3, ld_icw4, ld_mask, ld_ocw2, ld_ocw3;

    pic_wr_sync #(.DW(DW), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cs_n(cs_n), .a0(a0), .din(din),
        .evt(evt), .ev_a0(ev_a0), .ev_dat(ev_dat)
    );

    pic_seq_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .evt(evt), .ev_a0(ev_a0), .ev_dat(ev_dat),
        .flg_sngl(icw1_flags[1]), .flg_ic4(icw1_flags[0]), .ready(ready),
        .ld_icw1(ld_icw1), .ld_icw2(ld_icw2), .ld_icw3(ld_icw3), .ld_icw4(ld_icw4),
        .ld_mask(ld_mask), .ld_ocw2(ld_ocw2), .ld_ocw3(ld_ocw3)
    );

    pic_cfg_store #(.DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .ev_dat(ev_dat),
        .ld_icw1(ld_icw1), .ld_icw2(ld_icw2), .ld_icw3(ld_icw3), .ld_icw4(ld_icw4),
        .ld_mask(ld_mask), .ld_ocw2(ld_ocw2), .ld_ocw3(ld_ocw3),
        .icw1_flags(icw1_flags), .vec_base(vec_base), .casc_cfg(casc_cfg),
        .icw4_cfg(icw4_cfg), .mask(mask), .init_clear(init_clear),
        .ocw2_wr(ocw2_wr), .ocw3_wr(ocw3_wr), .ocw_data(ocw_data)
    );
endmodule

// File: rtl/pic_init_seq_chk.sv
// Checker: temporal properties of the sequencer, bound to the top module.
// Assumes the captured write signals of the synchronizer are visible.
module pic_init_seq_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          evt,
    input logic          ev_a0,
    input logic [DW-1:0] ev_dat,
    input logic          ready,
    input logic          init_clear,
    input logic [DW-1:0] mask,
    input logic [DW-1:0] casc_cfg,
    input logic [4:0]    icw4_cfg,
    input logic          ocw2_wr,
    input logic          ocw3_wr,
    input logic [DW-1:0] ocw_data
);
    // R1
    icw1_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !ev_a0 && ev_dat[4]) |=> !ready);

    // R2
    icw1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !ev_a0 && ev_dat[4]) |=>
            (mask == '0 && casc_cfg == '0 && icw4_cfg == '0 && init_clear));

    // R7
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(evt && ev_a0));

    // R8
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && ev_a0 && ready) |=> (mask == $past(ev_dat)));

    // R9
    ocw_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ocw2_wr || ocw3_wr) |-> ($past(ready) && !ocw_data[4]
                                  && (ocw_data[3] == ocw3_wr)));

    // R10
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> ($stable(mask) && $stable(ready) && !ocw2_wr && !ocw3_wr));
endmodule

bind pic_init_seq pic_init_seq_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt(evt), .ev_a0(ev_a0), .ev_dat(ev_dat),
    .ready(ready), .init_clear(init_clear), .mask(mask), .casc_cfg(casc_cfg),
    .icw4_cfg(icw4_cfg), .ocw2_wr(ocw2_wr), .ocw3_wr(ocw3_wr), .ocw_data(ocw_data)
);

// File: tb/tb_pic_init_seq.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_pic_init_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       a0 = 1'b0;
    logic [7:0] din = 8'h00;
    logic       ready, init_clear, ocw2_wr, ocw3_wr;
    logic [7:0] mask, casc_cfg, ocw_data;
    logic [4:0] vec_base, icw4_cfg;
    logic [3:0] icw1_flags;

    int n_chk = 0;
    int n_fail = 0;
    int n_clr = 0;
    int n_o2 = 0;
    int n_o3 = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pic_init_seq dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .a0(a0), .din(din),
        .ready(ready), .init_clear(init_clear), .mask(mask), .vec_base(vec_base),
        .casc_cfg(casc_cfg), .icw1_flags(icw1_flags), .icw4_cfg(icw4_cfg),
        .ocw2_wr(ocw2_wr), .ocw3_wr(ocw3_wr), .ocw_data(ocw_data)
    );

    // Pulse counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (init_clear) n_clr++;
            if (ocw2_wr)    n_o2++;
            if (ocw3_wr)    n_o3++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic adr, input logic [7:0] d, input logic sel_n);
        @(negedge clk);
        cs_n = sel_n; a0 = adr; din = d;
        @(negedge clk); wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(ready == 0 && mask == 0 && vec_base == 0 && casc_cfg == 0, "R12 reset regs",
            {ready, mask, vec_base, casc_cfg}, 0);
        chk(icw1_flags == 0 && icw4_cfg == 0 && !init_clear && !ocw2_wr && !ocw3_wr,
            "R12 reset flags", {icw1_flags, icw4_cfg, init_clear, ocw2_wr, ocw3_wr}, 0);
    endtask

    task automatic t_full_seq();
        int c0 = n_clr;
        bus_wr(1'b0, 8'h11, 1'b0);
        chk(!ready, "R1 ready low after first word", ready, 0);
        chk(n_clr == c0 + 1, "R2 one clear pulse", n_clr - c0, 1);
        chk(icw1_flags == 4'h1, "R2 flags", icw1_flags, 4'h1);
        bus_wr(1'b1, 8'h48, 1'b0);
        chk(vec_base == 5'h09, "R3 vector base", vec_base, 5'h09);
        chk(!ready, "R7 not ready after 2 of 4", ready, 0);
        bus_wr(1'b1, 8'h04, 1'b0);
        chk(casc_cfg == 8'h04, "R4 cascade word", casc_cfg, 8'h04);
        chk(!ready, "R7 not ready after 3 of 4", ready, 0);
        bus_wr(1'b1, 8'h1F, 1'b0);
        chk(icw4_cfg == 5'h1F, "R6 extended word", icw4_cfg, 5'h1F);
        chk(ready, "R7 ready after 4 words", ready, 1);
    endtask

    task automatic t_run_cmds();
        int o2 = n_o2;
        int o3 = n_o3;
        bus_wr(1'b1, 8'hA5, 1'b0);
        chk(mask == 8'hA5, "R8 mask load", mask, 8'hA5);
        bus_wr(1'b0, 8'h20, 1'b0);
        chk(n_o2 == o2 + 1 && n_o3 == o3, "R9 ocw2 pulse", n_o2 - o2, 1);
        chk(ocw_data == 8'h20, "R9 ocw2 data", ocw_data, 8'h20);
        bus_wr(1'b0, 8'h0A, 1'b0);
        chk(n_o3 == o3 + 1 && n_o2 == o2 + 1, "R9 ocw3 pulse", n_o3 - o3, 1);
        chk(ocw_data == 8'h0A, "R9 ocw3 data", ocw_data, 8'h0A);
    endtask

    task automatic t_cs_high();
        int o2 = n_o2;
        bus_wr(1'b1, 8'h3C, 1'b1);
        chk(mask == 8'hA5, "R10 mask kept with cs high", mask, 8'hA5);
        bus_wr(1'b0, 8'h00, 1'b1);
        chk(n_o2 == o2 && ready, "R10 no pulse with cs high", n_o2 - o2, 0);
    endtask

    task automatic t_single_ic4();
        bus_wr(1'b0, 8'h13, 1'b0);
        chk(mask == 0 && casc_cfg == 0 && icw4_cfg == 0, "R2 clears on restart",
            {mask, casc_cfg, icw4_cfg}, 0);
        chk(!ready, "R1 ready drops on restart", ready, 0);
        bus_wr(1'b1, 8'hF8, 1'b0);
        chk(vec_base == 5'h1F && !ready, "R3 vector base single", vec_base, 5'h1F);
        bus_wr(1'b1, 8'h03, 1'b0);
        chk(casc_cfg == 0, "R5 cascade word skipped", casc_cfg, 0);
        chk(icw4_cfg == 5'h03 && ready, "R6 extended word after skip", icw4_cfg, 5'h03);
    endtask

    task automatic t_two_words();
        bus_wr(1'b0, 8'h1A, 1'b0);
        chk(icw1_flags == 4'hA, "R2 flags level single", icw1_flags, 4'hA);
        bus_wr(1'b1, 8'h20, 1'b0);
        chk(vec_base == 5'h04, "R3 vector base short", vec_base, 5'h04);
        chk(ready && icw4_cfg == 0, "R6 no extended word, fields zero",
            {ready, icw4_cfg}, 6'h20);
    endtask

    task automatic t_casc_no_ic4();
        bus_wr(1'b0, 8'h10, 1'b0);
        bus_wr(1'b1, 8'h08, 1'b0);
        chk(!ready, "R4 waits for cascade word", ready, 0);
        bus_wr(1'b1, 8'h80, 1'b0);
        chk(casc_cfg == 8'h80 && ready && icw4_cfg == 0, "R4 cascade then done",
            {ready, casc_cfg, icw4_cfg}, {1'b1, 8'h80, 5'h00});
    endtask

    task automatic t_restart_and_stray();
        int o3 = n_o3;
        bus_wr(1'b0, 8'h11, 1'b0);
        bus_wr(1'b1, 8'h50, 1'b0);
        bus_wr(1'b0, 8'h12, 1'b0);
        bus_wr(1'b0, 8'h08, 1'b0);
        chk(n_o3 == o3 && !ready, "R11 stray write ignored", n_o3 - o3, 0);
        bus_wr(1'b1, 8'h30, 1'b0);
        chk(vec_base == 5'h06 && ready, "R1 restart mid sequence",
            {ready, vec_base}, {1'b1, 5'h06});
    endtask

    // Ready edge timing: wr_n rises at a negedge; ready due after the 3rd posedge.
    task automatic t_ready_timing();
        bus_wr(1'b0, 8'h12, 1'b0);
        @(negedge clk);
        cs_n = 1'b0; a0 = 1'b1; din = 8'h40;
        @(negedge clk); wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!ready, "R7 ready not early", ready, 0);
        @(negedge clk);
        chk(ready, "R7 ready on third edge", ready, 1);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_full_seq();
        t_run_cmds();
        t_cs_high();
        t_single_ic4();
        t_two_words();
        t_casc_no_ic4();
        t_restart_and_stray();
        t_ready_timing();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule